// File: doc/BRIEF.md
# Prefetch RAM Indirect Debug Port

This block lets software reach every word of a parity-protected prefetch RAM through two registers. Software first loads a 36-bit data register, which holds 32 data bits and 4 parity bits. It then writes a command word that names a channel, an entry, a direction and a parity mode. The block runs one RAM access on a fixed two-cycle schedule. While the access runs, the completion status reads low. It reads high again once a read result sits in the data register, or once a write has landed in the RAM.

A second job watches the RAM's normal-path reads. Every word returned on that path is checked for even parity per byte. The address of the first bad word is kept in a log together with a sticky error flag. Later errors leave the log as it is until software clears the flag and the log by writing 1 to the status clear bit.

Top module: `pref_dbg_port`

## Requirements
- R1: After reset, acc_done is 1, perr_flag is 0, perr_addr is 0, data_q is 0 and ram_en is 0.
- R2: A command is a bus write with bus_sel=1. Bits [6:5] carry the channel, bits [4:0] the entry, bit 30 the direction (1 = read, 0 = write) and bit 29 the parity-enable. In the cycle after an accepted command, ram_en is high for exactly one cycle, with ram_addr = {channel, entry} and ram_we = NOT bit 30.
- R3: After an accepted command, acc_done reads 0 for the next two clock cycles and reads 1 from the second rising edge after the command onward.
- R4: A read command leaves the addressed 36-bit RAM word (parity in bits 35:32, data in bits 31:0) in data_q by the time acc_done returns to 1.
- R5: A write command with parity-enable 1 stores data_q[35:32] unchanged as the word's parity bits, next to data_q[31:0].
- R6: A write command with parity-enable 0 stores generated even parity: stored bit 32+i is the XOR of data byte i (bits 8i+7..8i).
- R7: A command written while acc_done is 0 is ignored. It causes no RAM access and does not change when the running access completes.
- R8: A normal-path read (np_valid=1) whose bits 35:32 differ from the per-byte even parity of bits 31:0 sets perr_flag at the next edge and loads perr_addr with np_addr, provided the flag was clear.
- R9: While perr_flag is set, later parity errors leave perr_addr unchanged.
- R10: A bus write with bus_sel=2 and bus_wdata[0]=1 clears perr_flag and perr_addr to 0 at the next edge. With bus_wdata[0]=0 the write has no effect. A parity error in the same cycle as a clear is logged.
- R11: A bus write with bus_sel=0 loads all 36 bits of bus_wdata into data_q.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select: 0 data, 1 command, 2 status clear |
| bus_wdata | input | 36 | Register write data |
| np_valid | input | 1 | Normal-path read word valid |
| np_addr | input | 7 | Address of the normal-path read |
| np_data | input | 36 | Normal-path read word (parity in 35:32) |
| ram_rdata | input | 36 | RAM read data, one cycle after a read enable |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 7 | RAM address {channel, entry} |
| ram_wdata | output | 36 | RAM write word |
| data_q | output | 36 | Data register contents |
| acc_done | output | 1 | Completion status: 0 busy, 1 done |
| perr_flag | output | 1 | Sticky parity-error flag |
| perr_addr | output | 7 | Address of the first logged parity error |

## Verification
Suppose the sequencer is stuck or counts wrongly. Then acc_done fails to rise on the third edge after a command, or a RAM enable shows up at the wrong time or more than once. Both are visible within three cycles. A corrupted latched address or direction shows at ram_addr and ram_we in the very next cycle, and the stored word then reads back wrong. Corrupted log state shows at perr_addr or perr_flag one edge after the offending normal-path read or clear.

// File: rtl/pref_dbg_pkg.sv
package pref_dbg_pkg;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_CMD  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_RSVD = 2'd3
    } bus_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_CAPTURE = 2'd2
    } seq_state_e;

    localparam int CMD_READ_BIT  = 30;
    localparam int CMD_PAREN_BIT = 29;
    localparam int STAT_CLR_BIT  = 0;

    typedef struct packed {
        logic is_read;
        logic par_en;
    } acc_kind_t;

endpackage

// File: rtl/pref_dbg_parity.sv
module pref_dbg_parity #(
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8
) (
    input  logic [DATA_W-1:0] data,
    output logic [NB-1:0]     par
);
    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign par[b] = ^data[8*b +: 8];
    end
endmodule

// File: rtl/pref_dbg_seq.sv
module pref_dbg_seq
    import pref_dbg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 7,
    localparam int NB     = DATA_W / 8,
    localparam int WORD_W = DATA_W + NB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  acc_kind_t         kind_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [WORD_W-1:0] data_reg,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [WORD_W-1:0] ram_wdata,
    output logic              cap_en,
    output logic              busy
);
    seq_state_e        state_q;
    acc_kind_t         kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [NB-1:0]     gen_par;

    pref_dbg_parity #(.DATA_W(DATA_W)) u_gen (
        .data (data_reg[DATA_W-1:0]),
        .par  (gen_par)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            kind_q  <= '0;
            addr_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_ACCESS;
                        kind_q  <= kind_in;
                        addr_q  <= addr_in;
                    end
                end
                ST_ACCESS:  state_q <= ST_CAPTURE;
                ST_CAPTURE: state_q <= ST_IDLE;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ram_en    = (state_q == ST_ACCESS);
        ram_we    = ram_en && !kind_q.is_read;
        ram_addr  = addr_q;
        ram_wdata = {(kind_q.par_en ? data_reg[WORD_W-1:DATA_W] : gen_par),
                     data_reg[DATA_W-1:0]};
        cap_en    = (state_q == ST_CAPTURE) && kind_q.is_read;
        busy      = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/pref_dbg_perr_log.sv
module pref_dbg_perr_log #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 7,
    localparam int NB     = DATA_W / 8,
    localparam int WORD_W = DATA_W + NB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              np_valid,
    input  logic [ADDR_W-1:0] np_addr,
    input  logic [WORD_W-1:0] np_data,
    input  logic              clr,
    output logic              flag,
    output logic [ADDR_W-1:0] log_addr
);
    logic [NB-1:0] exp_par;
    logic          mismatch;

    pref_dbg_parity #(.DATA_W(DATA_W)) u_chk (
        .data (np_data[DATA_W-1:0]),
        .par  (exp_par)
    );

    assign mismatch = np_valid && (exp_par != np_data[WORD_W-1:DATA_W]);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag     <= 1'b0;
            log_addr <= '0;
        end else if (mismatch && (!flag || clr)) begin
            flag     <= 1'b1;
            log_addr <= np_addr;
        end else if (clr) begin
            flag     <= 1'b0;
            log_addr <= '0;
        end
    end
endmodule

// File: rtl/pref_dbg_port.sv
module pref_dbg_port
    import pref_dbg_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CHAN_W  = 2,
    parameter int ENTRY_W = 5,
    localparam int NB     = DATA_W / 8,
    localparam int WORD_W = DATA_W + NB,
    localparam int ADDR_W = CHAN_W + ENTRY_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [1:0]        bus_sel,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              np_valid,
    input  logic [ADDR_W-1:0] np_addr,
    input  logic [WORD_W-1:0] np_data,
    input  logic [WORD_W-1:0] ram_rdata,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [WORD_W-1:0] ram_wdata,
    output logic [WORD_W-1:0] data_q,
    output logic              acc_done,
    output logic              perr_flag,
    output logic [ADDR_W-1:0] perr_addr
);
    bus_sel_e  sel;
    logic      busy;
    logic      cap_en;
    logic      cmd_go;
    logic      stat_clr;
    acc_kind_t kind_in;

    assign sel      = bus_sel_e'(bus_sel);
    assign cmd_go   = bus_we && (sel == SEL_CMD) && !busy;
    assign stat_clr = bus_we && (sel == SEL_STAT) && bus_wdata[STAT_CLR_BIT];
    assign kind_in  = '{is_read: bus_wdata[CMD_READ_BIT],
                        par_en:  bus_wdata[CMD_PAREN_BIT]};
    assign acc_done = !busy;

    pref_dbg_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (cmd_go),
        .kind_in   (kind_in),
        .addr_in   (bus_wdata[ADDR_W-1:0]),
        .data_reg  (data_q),
        .ram_en    (ram_en),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .cap_en    (cap_en),
        .busy      (busy)
    );

    pref_dbg_perr_log #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_log (
        .clk      (clk),
        .rst      (rst),
        .np_valid (np_valid),
        .np_addr  (np_addr),
        .np_data  (np_data),
        .clr      (stat_clr),
        .flag     (perr_flag),
        .log_addr (perr_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (cap_en) begin
            data_q <= ram_rdata;
        end else if (bus_we && (sel == SEL_DATA)) begin
            data_q <= bus_wdata;
        end
    end
endmodule

// File: rtl/pref_dbg_port_chk.sv
module pref_dbg_port_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [1:0]        bus_sel,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              cmd_read,
    input logic              clr_bit,
    input logic              np_valid,
    input logic              ram_en,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              acc_done,
    input logic              perr_flag,
    input logic [ADDR_W-1:0] perr_addr
);
    logic go;
    logic clr;
    assign go  = bus_we && (bus_sel == 2'd1) && acc_done;
    assign clr = bus_we && (bus_sel == 2'd2) && clr_bit;

    AST_DONE_TIMING: assert property (@(posedge clk) disable iff (rst)
        go |=> !acc_done ##1 !acc_done ##1 acc_done); // R3

    AST_RAM_ADDR: assert property (@(posedge clk) disable iff (rst)
        go |=> ram_en && (ram_addr == $past(cmd_addr)) && (ram_we == !$past(cmd_read))); // R2

    AST_RAM_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ram_en |=> !ram_en); // R2

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (bus_sel == 2'd1) && !acc_done) |=> !ram_en); // R7

    AST_LOG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (perr_flag && !clr) |=> perr_flag && (perr_addr == $past(perr_addr))); // R9

    AST_LOG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr && !np_valid) |=> !perr_flag && (perr_addr == '0)); // R10
endmodule

bind pref_dbg_port pref_dbg_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_sel   (bus_sel),
    .cmd_addr  (bus_wdata[ADDR_W-1:0]),
    .cmd_read  (bus_wdata[30]),
    .clr_bit   (bus_wdata[0]),
    .np_valid  (np_valid),
    .ram_en    (ram_en),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .acc_done  (acc_done),
    .perr_flag (perr_flag),
    .perr_addr (perr_addr)
);

// File: tb/pref_dbg_port_tb.sv
module pref_dbg_port_tb;
    localparam int WORD_W = 36;
    localparam int ADDR_W = 7;
    localparam int DEPTH  = 128;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_we = 1'b0;
    logic [1:0]        bus_sel = 2'd0;
    logic [WORD_W-1:0] bus_wdata = '0;
    logic              np_valid = 1'b0;
    logic [ADDR_W-1:0] np_addr = '0;
    logic [WORD_W-1:0] np_data = '0;
    logic [WORD_W-1:0] ram_rdata;
    logic              ram_en, ram_we, acc_done, perr_flag;
    logic [ADDR_W-1:0] ram_addr, perr_addr;
    logic [WORD_W-1:0] ram_wdata, data_q;

    int checks = 0;
    int errors = 0;
    int ram_acc = 0;
    logic [ADDR_W-1:0] last_addr = '0;
    logic              last_we = 1'b0;
    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] rd_q = '0;

    always #4 clk = ~clk;

    pref_dbg_port u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .np_valid(np_valid), .np_addr(np_addr),
        .np_data(np_data), .ram_rdata(ram_rdata), .ram_en(ram_en),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .data_q(data_q), .acc_done(acc_done), .perr_flag(perr_flag),
        .perr_addr(perr_addr)
    );

    assign ram_rdata = rd_q;

    always @(posedge clk) begin
        if (ram_en) begin
            ram_acc   <= ram_acc + 1;
            last_addr <= ram_addr;
            last_we   <= ram_we;
            if (ram_we) mem[ram_addr] <= ram_wdata;
            else        rd_q <= mem[ram_addr];
        end
    end

    function automatic logic [3:0] exp_par(input logic [31:0] d);
        logic [3:0] p;
        for (int b = 0; b < 4; b++) p[b] = ^d[8*b +: 8];
        return p;
    endfunction

    function automatic logic [WORD_W-1:0] mk_cmd(input logic rd, input logic pen,
                                                 input logic [ADDR_W-1:0] a);
        logic [WORD_W-1:0] w;
        w = '0;
        w[30] = rd;
        w[29] = pen;
        w[ADDR_W-1:0] = a;
        return w;
    endfunction

    task automatic check_eq(input string req, input string what,
                            input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // All tasks are entered at a falling edge and return at a falling edge.
    task automatic bus_write(input logic [1:0] sel, input logic [WORD_W-1:0] d);
        bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic issue_cmd(input logic [WORD_W-1:0] cmd);
        bus_write(2'd1, cmd);
        check_eq("R3", "done after cmd edge", {35'd0, acc_done}, 36'd0);
        @(negedge clk);
        check_eq("R3", "done one cycle later", {35'd0, acc_done}, 36'd0);
        @(negedge clk);
        check_eq("R3", "done two cycles later", {35'd0, acc_done}, 36'd1);
    endtask

    task automatic np_read(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d);
        np_valid = 1'b1; np_addr = a; np_data = d;
        @(negedge clk);
        np_valid = 1'b0;
    endtask

    task automatic t_reset;
        check_eq("R1", "acc_done", {35'd0, acc_done}, 36'd1);
        check_eq("R1", "perr_flag", {35'd0, perr_flag}, 36'd0);
        check_eq("R1", "perr_addr", {29'd0, perr_addr}, 36'd0);
        check_eq("R1", "data_q", data_q, 36'd0);
        check_eq("R1", "ram_en", {35'd0, ram_en}, 36'd0);
    endtask

    task automatic t_write_gen;
        logic [31:0] d;
        d = 32'h1234_5678;
        bus_write(2'd0, {4'h0, d});
        issue_cmd(mk_cmd(1'b0, 1'b0, 7'h45));
        check_eq("R2", "write address", {29'd0, last_addr}, 36'h45);
        check_eq("R2", "write strobe", {35'd0, last_we}, 36'd1);
        check_eq("R6", "generated parity word", mem[7'h45], {exp_par(d), d});
    endtask

    task automatic t_write_inj;
        logic [31:0] d;
        d = 32'h0F0F_00FF;
        bus_write(2'd0, {4'hA, d});
        issue_cmd(mk_cmd(1'b0, 1'b1, 7'h13));
        check_eq("R5", "injected parity word", mem[7'h13], {4'hA, d});
    endtask

    task automatic t_read;
        mem[7'h6C] = 36'h9_DEAD_BEEF;
        bus_write(2'd0, 36'h0_0000_0000);
        issue_cmd(mk_cmd(1'b1, 1'b0, 7'h6C));
        check_eq("R2", "read address", {29'd0, last_addr}, 36'h6C);
        check_eq("R2", "read strobe", {35'd0, last_we}, 36'd0);
        check_eq("R4", "read data", data_q, 36'h9_DEAD_BEEF);
    endtask

    task automatic t_busy;
        int base;
        mem[7'h21] = 36'h3_CAFE_F00D;
        mem[7'h30] = 36'h0;
        bus_write(2'd0, 36'h5_5555_AAAA);
        base = ram_acc;
        bus_write(2'd1, mk_cmd(1'b1, 1'b0, 7'h21));
        bus_write(2'd1, mk_cmd(1'b0, 1'b0, 7'h30));
        check_eq("R7", "still busy", {35'd0, acc_done}, 36'd0);
        @(negedge clk);
        check_eq("R7", "done on time", {35'd0, acc_done}, 36'd1);
        repeat (4) @(negedge clk);
        check_eq("R7", "single access", 36'(ram_acc - base), 36'd1);
        check_eq("R7", "ignored write target", mem[7'h30], 36'h0);
        check_eq("R7", "first read result", data_q, 36'h3_CAFE_F00D);
    endtask

    task automatic t_perr;
        logic [31:0] d;
        d = 32'hA5C3_0171;
        np_read(7'h05, {exp_par(d), d});
        check_eq("R8", "good word flag", {35'd0, perr_flag}, 36'd0);
        np_read(7'h11, {~exp_par(d), d});
        check_eq("R8", "bad word flag", {35'd0, perr_flag}, 36'd1);
        check_eq("R8", "bad word addr", {29'd0, perr_addr}, 36'h11);
        np_read(7'h22, {exp_par(d) ^ 4'h2, d});
        check_eq("R9", "second error addr", {29'd0, perr_addr}, 36'h11);
        bus_write(2'd2, 36'h0);
        check_eq("R10", "clear bit 0 flag", {35'd0, perr_flag}, 36'd1);
        check_eq("R10", "clear bit 0 addr", {29'd0, perr_addr}, 36'h11);
        bus_write(2'd2, 36'h1);
        check_eq("R10", "cleared flag", {35'd0, perr_flag}, 36'd0);
        check_eq("R10", "cleared addr", {29'd0, perr_addr}, 36'h0);
        np_read(7'h22, {exp_par(d) ^ 4'h8, d});
        check_eq("R9", "relogged addr", {29'd0, perr_addr}, 36'h22);
    endtask

    task automatic t_data_reg;
        bus_write(2'd0, 36'hC_8765_4321);
        check_eq("R11", "data register", data_q, 36'hC_8765_4321);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write_gen();
        t_write_inj();
        t_read();
        t_busy();
        t_perr();
        t_data_reg();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule